// File: doc/BRIEF.md
# Thread Fetch Selector

This block decides, every cycle, which hardware thread the front-end fetch stage serves. It receives a status code for each thread, a mask of the threads that are active, a policy select and a fixed thread number for the single-thread policy. It returns a valid flag and a thread number. The selection is combinational, so a change on the inputs shows on the grant in the same cycle.

Under the round-robin policy the block keeps an ordered list of every thread number. It walks this list from head to tail and grants the first thread whose status allows fetching. When the consumer takes that grant, the winner moves to the tail of the list and the other entries keep their relative order. A selection mode is decoded from the inputs: SEL_NONE when no thread is active, SEL_ONLY when exactly one is active, SEL_FIXED when several are active under the single-thread policy, and SEL_ROUND when several are active under round-robin. The mode is decoded again every cycle from the inputs present in that cycle. Only SEL_ROUND, with a grant issued and `accept` high at the clock edge, changes the list.

Top module: `thread_fetch_sel`

## Requirements
- R1: After reset the priority list holds 0, 1, …, N-1 from head to tail. If every thread is eligible and every grant is accepted, round-robin therefore grants 0, 1, 2, 3, 0, … in turn.
- R2: A thread status is 3 bits wide. Codes 0 (running), 1 (idle) and 2 (unblocking) are eligible. Codes 3 (blocked), 4 (squashing) and 5 to 7 are not eligible. Thread t uses bits [3t+2:3t] of `thr_status`.
- R3: With two or more active threads and `policy`=1 (round-robin), the grant is valid and names the first eligible thread in list order, whatever its bit in the active mask.
- R4: When a round-robin grant is valid and `accept` is high at a clock edge, the granted entry moves to the tail of the list and the other entries keep their order.
- R5: Without `accept`, or in any mode other than round-robin, the list does not change, so the same inputs give the same grant on the next cycle.
- R6: In round-robin mode, if no thread is eligible, `grant_valid` is 0 and the list does not change.
- R7: With two or more active threads and `policy`=0 (single-thread), `grant_valid` is 1 and `grant_tid` equals `fixed_tid`, with no eligibility check.
- R8: With exactly one active thread, that thread is granted if it is eligible, and otherwise `grant_valid` is 0.
- R9: With no active thread, `grant_valid` is 0.
- R10: The grant depends combinationally on the current inputs and the list, with no register delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| thr_status | input | 3*N | Per-thread status codes |
| active_mask | input | N | One bit per active thread |
| policy | input | 1 | 0 = single-thread, 1 = round-robin |
| fixed_tid | input | TIDW | Thread granted under the single-thread policy |
| accept | input | 1 | Consumer takes the current grant |
| grant_valid | output | 1 | A thread is granted |
| grant_tid | output | TIDW | Granted thread number |

## Verification
The bench targets list order after repeated rotations. A rotating pointer, or a move-to-tail that reorders the other entries, drifts away from the reference queue within a few accepts. It also makes cycles with a grant but no accept, and mode changes while the list is not in reset order. A design that rotates on those cycles returns the wrong thread on the next round-robin grant. It covers the boundaries of the active count (zero, one with an eligible or blocked status, several) and status codes 5 to 7. A design that counts the mask wrongly, or checks eligibility under the single-thread policy, shows a wrong valid flag there.

// File: rtl/tfs_pkg.sv
package tfs_pkg;

    typedef enum logic [2:0] {
        TS_RUN     = 3'd0,
        TS_IDLE    = 3'd1,
        TS_UNBLOCK = 3'd2,
        TS_BLOCKED = 3'd3,
        TS_SQUASH  = 3'd4
    } thr_state_e;

    typedef enum logic {
        POL_SINGLE = 1'b0,
        POL_ROUND  = 1'b1
    } fetch_pol_e;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_ONLY,
        SEL_FIXED,
        SEL_ROUND
    } sel_mode_e;

endpackage

// File: rtl/tfs_eligible.sv
module tfs_eligible #(
    parameter int N = 4
) (
    input  logic [3*N-1:0] status,
    output logic [N-1:0]   elig
);
    import tfs_pkg::*;

    for (genvar t = 0; t < N; t++) begin : g_thr
        always_comb begin
            case (status[3*t +: 3])
                TS_RUN, TS_IDLE, TS_UNBLOCK: elig[t] = 1'b1;
                default:                     elig[t] = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/tfs_rr_scan.sv
module tfs_rr_scan #(
    parameter int N    = 4,
    parameter int TIDW = 2
) (
    input  logic [N*TIDW-1:0] list_flat,
    input  logic [N-1:0]      elig,
    output logic              hit,
    output logic [TIDW-1:0]   pos,
    output logic [TIDW-1:0]   id
);
    // Walk tail to head so the head-most eligible entry wins last.
    always_comb begin
        hit = 1'b0;
        pos = '0;
        id  = '0;
        for (int p = N - 1; p >= 0; p--) begin
            if (elig[list_flat[p*TIDW +: TIDW]]) begin
                hit = 1'b1;
                pos = TIDW'(p);
                id  = list_flat[p*TIDW +: TIDW];
            end
        end
    end

endmodule

// File: rtl/tfs_prio_list.sv
module tfs_prio_list #(
    parameter int N    = 4,
    parameter int TIDW = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rotate,
    input  logic [TIDW-1:0]   win_pos,
    output logic [N*TIDW-1:0] list_flat
);
    logic [TIDW-1:0] ent [N];
    logic [TIDW-1:0] win_id;

    assign win_id = ent[win_pos];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int p = 0; p < N; p++) ent[p] <= TIDW'(p);
        end else if (rotate) begin
            for (int p = 0; p < N; p++) begin
                if (p == N - 1)
                    ent[p] <= win_id;
                else if (TIDW'(p) >= win_pos)
                    ent[p] <= ent[p + 1];
            end
        end
    end

    for (genvar p = 0; p < N; p++) begin : g_flat
        assign list_flat[p*TIDW +: TIDW] = ent[p];
    end

    AST_LIST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rotate |=> $stable(list_flat)); // R5
    AST_TAIL_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
        rotate |=> list_flat[(N-1)*TIDW +: TIDW] == $past(win_id)); // R4

endmodule

// File: rtl/thread_fetch_sel.sv
module thread_fetch_sel #(
    parameter int N    = 4,
    parameter int TIDW = (N > 1) ? $clog2(N) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3*N-1:0]    thr_status,
    input  logic [N-1:0]      active_mask,
    input  logic              policy,
    input  logic [TIDW-1:0]   fixed_tid,
    input  logic              accept,
    output logic              grant_valid,
    output logic [TIDW-1:0]   grant_tid
);
    import tfs_pkg::*;

    localparam int CNTW = $clog2(N + 1);

    logic [N-1:0]      elig;
    logic [N*TIDW-1:0] list_flat;
    logic              rr_hit;
    logic [TIDW-1:0]   rr_pos;
    logic [TIDW-1:0]   rr_id;
    logic [TIDW-1:0]   only_tid;
    logic [CNTW-1:0]   act_cnt;
    logic              rotate;
    sel_mode_e         mode;
    fetch_pol_e        pol;

    assign pol     = fetch_pol_e'(policy);
    assign act_cnt = CNTW'($countones(active_mask));

    tfs_eligible #(.N(N)) u_elig (
        .status (thr_status),
        .elig   (elig)
    );

    tfs_rr_scan #(.N(N), .TIDW(TIDW)) u_scan (
        .list_flat (list_flat),
        .elig      (elig),
        .hit       (rr_hit),
        .pos       (rr_pos),
        .id        (rr_id)
    );

    tfs_prio_list #(.N(N), .TIDW(TIDW)) u_list (
        .clk       (clk),
        .rst_n     (rst_n),
        .rotate    (rotate),
        .win_pos   (rr_pos),
        .list_flat (list_flat)
    );

    // Mode decode
    always_comb begin
        if (act_cnt == '0)
            mode = SEL_NONE;
        else if (act_cnt == CNTW'(1))
            mode = SEL_ONLY;
        else if (pol == POL_SINGLE)
            mode = SEL_FIXED;
        else
            mode = SEL_ROUND;
    end

    always_comb begin
        only_tid = '0;
        for (int t = 0; t < N; t++) begin
            if (active_mask[t]) only_tid = TIDW'(t);
        end
    end

    // Outputs per mode
    always_comb begin
        grant_valid = 1'b0;
        grant_tid   = '0;
        rotate      = 1'b0;
        unique case (mode)
            SEL_NONE: begin
                grant_valid = 1'b0;
            end
            SEL_ONLY: begin
                grant_valid = elig[only_tid];
                grant_tid   = only_tid;
            end
            SEL_FIXED: begin
                grant_valid = 1'b1;
                grant_tid   = fixed_tid;
            end
            SEL_ROUND: begin
                grant_valid = rr_hit;
                grant_tid   = rr_id;
                rotate      = rr_hit & accept;
            end
            default: begin
                grant_valid = 1'b0;
            end
        endcase
    end

    AST_ZERO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (active_mask == '0) |-> !grant_valid); // R9
    AST_FIXED_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (!policy && $countones(active_mask) > 1) |-> (grant_valid && grant_tid == fixed_tid)); // R7
    AST_ROUND_ELIG: assert property (@(posedge clk) disable iff (!rst_n)
        (policy && $countones(active_mask) > 1 && grant_valid) |-> elig[grant_tid]); // R3
    AST_NO_ELIG_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (policy && $countones(active_mask) > 1 && elig == '0) |-> !grant_valid); // R6

endmodule

// File: tb/tb_thread_fetch_sel.sv
module tb_thread_fetch_sel;

    localparam int N    = 4;
    localparam int TIDW = 2;

    logic            clk = 1'b0;
    logic            rst_n;
    logic [3*N-1:0]  thr_status;
    logic [N-1:0]    active_mask;
    logic            policy;
    logic [TIDW-1:0] fixed_tid;
    logic            accept;
    logic            grant_valid;
    logic [TIDW-1:0] grant_tid;

    int n_checks = 0;
    int n_fail   = 0;
    int q[$];

    always #10 clk = ~clk;

    thread_fetch_sel #(.N(N), .TIDW(TIDW)) dut (
        .clk(clk), .rst_n(rst_n), .thr_status(thr_status),
        .active_mask(active_mask), .policy(policy), .fixed_tid(fixed_tid),
        .accept(accept), .grant_valid(grant_valid), .grant_tid(grant_tid)
    );

    function automatic bit ok_state(int code);
        return code <= 2;
    endfunction

    function automatic int st(int t);
        return int'(thr_status[3*t +: 3]);
    endfunction

    // Reference step: compare now, then update queue for the coming edge.
    task automatic step(input string tag);
        int  cnt = 0;
        int  only = 0;
        bit  ev = 0;
        int  et = 0;
        int  wpos = -1;
        #2;
        for (int t = 0; t < N; t++) if (active_mask[t]) begin cnt++; only = t; end
        if (cnt == 0) ev = 0;
        else if (cnt == 1) begin ev = ok_state(st(only)); et = only; end
        else if (!policy) begin ev = 1; et = int'(fixed_tid); end
        else begin
            for (int i = 0; i < q.size(); i++) begin
                if (ok_state(st(q[i]))) begin wpos = i; break; end
            end
            ev = (wpos >= 0);
            if (ev) et = q[wpos];
        end
        n_checks++;
        if (grant_valid !== ev || (ev && int'(grant_tid) != et)) begin
            n_fail++;
            $display("FAIL %s: valid=%0b tid=%0d expected valid=%0b tid=%0d",
                     tag, grant_valid, grant_tid, ev, et);
        end
        if (cnt > 1 && policy && wpos >= 0 && accept) begin
            int w = q[wpos];
            q.delete(wpos);
            q.push_back(w);
        end
        @(negedge clk);
    endtask

    task automatic drive(input logic [3*N-1:0] s, input logic [N-1:0] a,
                         input logic p, input int f, input logic acc);
        thr_status = s; active_mask = a; policy = p;
        fixed_tid = TIDW'(f); accept = acc;
    endtask

    initial begin
        #(20 * 200000);
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        drive('0, '0, 1'b1, 0, 1'b0);
        for (int i = 0; i < N; i++) q.push_back(i);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R9: nothing active
        drive('0, '0, 1'b1, 0, 1'b1); step("R9");
        // R1/R4: reset order and rotation with all running
        for (int k = 0; k < 6; k++) begin
            drive('0, 4'hF, 1'b1, 0, 1'b1); step("R1");
        end
        // R5: no accept keeps grant
        for (int k = 0; k < 3; k++) begin
            drive('0, 4'hF, 1'b1, 0, 1'b0); step("R5");
        end
        // R2: blocked/squash/5..7 skipped; idle and unblock taken
        drive({3'd7, 3'd2, 3'd3, 3'd4}, 4'hF, 1'b1, 0, 1'b1); step("R2");
        drive({3'd1, 3'd5, 3'd6, 3'd3}, 4'hF, 1'b1, 0, 1'b1); step("R2");
        // R3: eligibility ignores mask bit in round-robin
        drive({3'd0, 3'd3, 3'd3, 3'd3}, 4'b0011, 1'b1, 0, 1'b1); step("R3");
        // R6: none eligible, list unchanged afterwards
        drive({3'd3, 3'd4, 3'd5, 3'd7}, 4'hF, 1'b1, 0, 1'b1); step("R6");
        drive('0, 4'hF, 1'b1, 0, 1'b0); step("R6");
        // R7: fixed id, even if blocked, list untouched
        drive({4{3'd3}}, 4'b0110, 1'b0, 3, 1'b1); step("R7");
        drive('0, 4'hF, 1'b0, 1, 1'b1); step("R7");
        drive('0, 4'hF, 1'b1, 0, 1'b0); step("R7");
        // R8: single active thread
        drive({3'd0, 3'd3, 3'd0, 3'd0}, 4'b0100, 1'b1, 0, 1'b1); step("R8");
        drive({3'd0, 3'd2, 3'd0, 3'd0}, 4'b0100, 1'b0, 1, 1'b1); step("R8");
        drive({3'd4, 3'd0, 3'd0, 3'd0}, 4'b1000, 1'b1, 0, 1'b1); step("R8");
        // R10: same-cycle response to input change
        drive('0, 4'hF, 1'b0, 2, 1'b0); #1;
        policy = 1'b0; fixed_tid = 2'd0; step("R10");

        // Mixed traffic
        for (int k = 0; k < 2000; k++) begin
            logic [3*N-1:0] s;
            for (int t = 0; t < N; t++) s[3*t +: 3] = ($urandom_range(0, 3) == 0) ? 3'($urandom_range(3, 7)) : 3'($urandom_range(0, 2));
            drive(s, N'($urandom_range(0, 15)), ($urandom_range(0, 4) != 0),
                  $urandom_range(0, 3), 1'($urandom_range(0, 1)));
            step("R4");
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule